// File: doc/BRIEF.md
# Byte-Serial CSR Target with Parity

This block is a small register file reached over a narrow 9-bit control and status bus. Each lane carries 8 data bits and one odd-parity bit. A command names one 32-bit register, gives a direction (read or write) and may carry a poison flag. The block latches the command and then steps through a fixed schedule. After the command cycle come four byte slots of two cycles each, with the least significant byte first. In total a transfer takes nine cycles.

On a read, the block picks the register by the latched address and the byte by the slot number. It drives that byte onto the bus with generated parity and also checks the parity it sees on the bus. On a write, it samples the bus in the second cycle of each slot and stores the byte only if its parity is good. A bad byte is dropped, and bytes already written in the same transfer keep their new values. A poisoned read inverts the outgoing parity bit so that receivers see bad data.

Top module: `csr_bytelink`

## Requirements
- R1: After reset `bus_oe` and `rd_par_err` are low and every register reads back as zero.
- R2: A `cmd_valid` pulse while idle latches the command, and the transfer then occupies exactly the eight following cycles. A `cmd_valid` that arrives during a transfer is ignored.
- R3: On a read, byte k (bits 8k+7 to 8k) of the addressed register is driven on `bus_out[7:0]` in cycles 2k+1 and 2k+2 after the command cycle, for k from 0 to 3.
- R4: Every lane driven without poison has odd parity: the XOR of `bus_out[8:0]` is 1, with the parity bit in bit 8.
- R5: A read whose command carried `cmd_poison` drives all four lanes with the parity bit inverted, so that the XOR of `bus_out[8:0]` is 0.
- R6: On a write, byte k is taken from `bus_in[7:0]` in cycle 2k+2 after the command cycle. That is the second cycle of the slot and the only cycle in which the internal load enable is high.
- R7: A write byte whose lane fails odd parity is not stored. The other bytes of the same transfer are still stored.
- R8: On a read, `bus_in` is checked in the second cycle of each slot. A parity failure gives a one-cycle `rd_par_err` pulse in the next cycle.
- R9: Addresses at or above NUM_REGS (4) are unmapped. Writes to them change no register, and reads of them return zero data.
- R10: `bus_oe` is high only during the eight slot cycles of a read. It stays low when idle and throughout writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 4 | Register address |
| cmd_poison | input | 1 | Invert outgoing parity for this read |
| bus_in | input | 9 | Lane seen on the bus: {parity, data} |
| bus_out | output | 9 | Lane driven by the block: {parity, data} |
| bus_oe | output | 1 | Output enable for `bus_out` |
| rd_par_err | output | 1 | Parity error pulse seen during a read |

## Verification
Some properties are checked on every cycle by the assertions. These are the sequencer's step-by-step count and its fixed length, that a command during a transfer is ignored, that write bytes with bad parity and unmapped writes leave the register file unchanged, that unmapped reads give zero data, and that driven lanes have the right parity polarity. Only the bench scenarios can show the rest: the byte order across slots, the contents read back after partial writes, the timing of the error pulse and the poison behaviour seen from outside. They do this by comparing every cycle against a behavioural model.

// File: rtl/csr_bytelink_pkg.sv
package csr_bytelink_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_W = BYTE_W + 1;

  typedef logic [LANE_W-1:0] lane_t;

  // parity bit that makes the whole lane XOR to 1
  function automatic logic odd_bit(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction

  function automatic logic lane_ok(input lane_t l);
    return ^l;
  endfunction
endpackage

// File: rtl/csr_seq.sv
module csr_seq #(
  parameter int ADDR_W    = 4,
  parameter int NUM_BYTES = 4,
  localparam int BIDX_W   = $clog2(NUM_BYTES),
  localparam int CNT_W    = BIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_poison,
  output logic              busy,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr_q,
  output logic              poison_q,
  output logic [BIDX_W-1:0] byte_idx,
  output logic              ld_en
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * NUM_BYTES - 1);

  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              busy_nx, wr_nx, pois_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              take;

  assign take = cmd_valid & ~busy;

  always_comb begin
    busy_nx = busy;
    cnt_nx  = cnt;
    wr_nx   = is_write;
    addr_nx = addr_q;
    pois_nx = poison_q;
    if (take) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
      wr_nx   = cmd_write;
      addr_nx = cmd_addr;
      pois_nx = cmd_poison;
    end else if (busy) begin
      cnt_nx = cnt + CNT_W'(1);
      if (cnt == CNT_LAST) begin
        busy_nx = 1'b0;
        cnt_nx  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      is_write <= 1'b0;
      addr_q   <= '0;
      poison_q <= 1'b0;
    end else begin
      busy     <= busy_nx;
      cnt      <= cnt_nx;
      is_write <= wr_nx;
      addr_q   <= addr_nx;
      poison_q <= pois_nx;
    end
  end

  assign byte_idx = cnt[CNT_W-1:1];
  assign ld_en    = busy & cnt[0];

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> (busy && cnt == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNT_LAST) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
  assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == CNT_LAST));
  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(addr_q) && $stable(is_write)));
  assert_ld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !ld_en);
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_bytelink_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int BIDX_W    = $clog2(NUM_BYTES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [BIDX_W-1:0]                byte_idx,
  input  lane_t                            lane_in,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  logic mapped, par_ok, wr_hit;

  assign mapped = ({1'b0, addr} < (ADDR_W + 1)'(NUM_REGS));
  assign par_ok = lane_ok(lane_in);
  assign wr_hit = wr_en & par_ok & mapped;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic ce;
      assign ce = wr_hit & (addr == ADDR_W'(r)) & (byte_idx == BIDX_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs[r][b*BYTE_W +: BYTE_W] <= '0;
        else if (ce) regs[r][b*BYTE_W +: BYTE_W] <= lane_in[BYTE_W-1:0];
      end
    end
  end

  assert_drop_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lane_ok(lane_in)) |=> $stable(regs));
  assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(regs));
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux
  import csr_bytelink_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int BIDX_W    = $clog2(NUM_BYTES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [BIDX_W-1:0]                byte_idx,
  input  logic                             poison,
  output lane_t                            lane_out
);
  logic [DATA_W-1:0] sel_reg;
  logic [BYTE_W-1:0] sel_byte;

  // first selector: register by address, zero when unmapped
  always_comb begin
    sel_reg = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr == ADDR_W'(r)) sel_reg = regs[r];
    end
  end

  // second selector: byte by sequencer phase
  assign sel_byte = sel_reg[byte_idx*BYTE_W +: BYTE_W];
  assign lane_out = {odd_bit(sel_byte) ^ poison, sel_byte};

  assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, addr} >= (ADDR_W + 1)'(NUM_REGS)) |-> (lane_out[BYTE_W-1:0] == '0));
endmodule

// File: rtl/csr_bytelink.sv
module csr_bytelink
  import csr_bytelink_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int BIDX_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_poison,
  input  logic [8:0]        bus_in,
  output logic [8:0]        bus_out,
  output logic              bus_oe,
  output logic              rd_par_err
);
  logic                            busy, is_write, poison_q, ld_en;
  logic [ADDR_W-1:0]               addr_q;
  logic [BIDX_W-1:0]               byte_idx;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  lane_t                           lane_rd;
  logic                            err_nx;

  csr_seq #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_poison(cmd_poison), .busy(busy),
    .is_write(is_write), .addr_q(addr_q), .poison_q(poison_q),
    .byte_idx(byte_idx), .ld_en(ld_en));

  csr_regs #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_en & is_write), .addr(addr_q),
    .byte_idx(byte_idx), .lane_in(bus_in), .regs(regs));

  csr_rdmux #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .regs(regs), .addr(addr_q), .byte_idx(byte_idx),
    .poison(poison_q), .lane_out(lane_rd));

  assign bus_oe  = busy & ~is_write;
  assign bus_out = bus_oe ? lane_rd : '0;

  assign err_nx = ld_en & ~is_write & ~lane_ok(bus_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_par_err <= 1'b0;
    else        rd_par_err <= err_nx;
  end

  assert_oe_rd_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (busy && !is_write));
  assert_odd_par_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !poison_q) |-> (^bus_out));
  assert_poison_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && poison_q) |-> !(^bus_out));
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_par_err |-> !$past(is_write));
endmodule

// File: tb/sim_csr_bytelink.sv
module sim_csr_bytelink;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_poison = 1'b0;
  logic [3:0] cmd_addr = '0;
  logic [8:0] bus_in = '0;
  logic [8:0] bus_out;
  logic       bus_oe, rd_par_err;

  int total = 0, bad = 0;
  logic [31:0] mem [4];
  logic exp_err = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_bytelink u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_poison(cmd_poison),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rd_par_err(rd_par_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one full transfer; model compared on every cycle
  task automatic xfer(input bit wr, input logic [3:0] addr, input logic [31:0] data,
                      input bit pois, input logic [3:0] badm, input bit inject,
                      input string req);
    @(negedge clk);
    chk("R10", bus_oe, 0);
    cmd_valid = 1; cmd_write = wr; cmd_addr = addr; cmd_poison = pois; bus_in = '0;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      int s = k / 2;
      logic [7:0] b, d;
      @(negedge clk);
      cmd_valid = (inject && k == 3); cmd_write = 0; cmd_addr = 4'd1; cmd_poison = 0;
      b = (addr < 4) ? mem[addr][s*8 +: 8] : 8'h00;
      chk(wr ? "R10" : "R3", bus_oe, !wr);
      if (!wr) begin
        chk({req, " R3"}, bus_out[7:0], b);
        chk(pois ? "R5" : "R4", ^bus_out, !pois);
      end
      chk("R8", rd_par_err, exp_err);
      d = data[s*8 +: 8];
      if (wr) bus_in = {~(^d) ^ badm[s], d};
      else    bus_in = {~(^b) ^ badm[s], b};
      exp_err = 0;
      if (k % 2 == 1) begin
        if (wr && !badm[s] && addr < 4) mem[addr][s*8 +: 8] = d;
        if (!wr) exp_err = badm[s];
      end
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 0; bus_in = '0;
    chk("R2", bus_oe, 0);
    chk("R8", rd_par_err, exp_err);
    exp_err = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = '0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", bus_oe, 0);
    chk("R1", rd_par_err, 0);
    for (int i = 0; i < 4; i++) xfer(0, 4'(i), 0, 0, 0, 0, "R1");
    xfer(1, 4'd0, 32'hA5C3_1E7F, 0, 0, 0, "R6");
    xfer(1, 4'd1, 32'h0000_00FF, 0, 0, 0, "R6");
    xfer(1, 4'd3, 32'hFFFF_FFFF, 0, 0, 0, "R6");
    xfer(0, 4'd0, 0, 0, 0, 0, "R6");
    xfer(0, 4'd1, 0, 0, 0, 0, "R6");
    xfer(0, 4'd3, 0, 0, 0, 0, "R6");
    xfer(1, 4'd2, 32'h1122_3344, 0, 4'b0100, 0, "R7");
    xfer(0, 4'd2, 0, 0, 0, 0, "R7");
    xfer(1, 4'd2, 32'hDEAD_BEEF, 0, 4'b1001, 0, "R7");
    xfer(0, 4'd2, 0, 0, 0, 0, "R7");
    xfer(0, 4'd1, 0, 1, 0, 0, "R5");
    xfer(0, 4'd0, 0, 0, 4'b1001, 0, "R8");
    xfer(0, 4'd3, 0, 0, 4'b0110, 0, "R8");
    xfer(1, 4'd9, 32'h7777_7777, 0, 0, 0, "R9");
    xfer(0, 4'd9, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) xfer(0, 4'(i), 0, 0, 0, 0, "R9");
    xfer(1, 4'd3, 32'h0102_0304, 0, 0, 1, "R2");
    xfer(0, 4'd3, 0, 0, 0, 1, "R2");
    xfer(0, 4'd1, 0, 0, 0, 0, "R2");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule